// File: doc/BRIEF.md
# Periodic Tick Down-Counter

A 24-bit down-counting timer that produces a regular heartbeat for a processor. Software programs a reload count and then sets the enable bit. The counter loads that count and decrements once per step. A step is either every core clock or every pulse on an external reference tick input, chosen by a control bit. When the count goes from 1 to 0, a sticky "reached zero" flag is set and, if enabled, a one-cycle interrupt pulse is raised. On the next clock the count is refilled from the reload register, so the period is the reload value plus one.

Software reaches four 32-bit registers through a simple single-cycle bus. Writes take effect on the clock edge. Read data is returned combinationally in the same cycle.

- 0x10 is control and status.
- 0x14 holds the reload count.
- 0x18 shows the live count.
- 0x1C is a read-only calibration word.

Reading the control and status register clears the sticky flag. Writing any value to the live-count register zeroes the count and clears the flag, and raises no interrupt.

The counter is a three-state machine:

- **OFF**: idle, count held.
- **RUN**: counting down.
- **WRAP**: the single cycle in which the count is 0 before it is refilled.

Its transitions are:

- **OFF→RUN** on *start*: enabled with a nonzero reload.
- **RUN→RUN** on *step*: decrement.
- **RUN→WRAP** on *expire*: a step at count 1, or a write to the live count while enabled.
- **RUN→OFF** on *halt*: enable cleared.
- **WRAP→RUN** on *refill*.
- **WRAP→OFF** on *park*: enable cleared, or reload equal to 0.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and live-count registers read 0. The word at 0x1C reads {bit31 = no-reference indication, bit30 = inexact-calibration indication, bits 29:24 = 0, bits 23:0 = ten-millisecond count}, taken from parameters. Writes to 0x1C change nothing.
- R2: Register offsets are 0x10 control/status, 0x14 reload and 0x18 live count. Reload keeps bits 23:0 of a write and reads 0 above them. Any other address reads 0.
- R3: Control bit 0 is enable, bit 1 is interrupt enable, and bit 2 is the step source (1 = every core clock, 0 = reference tick pulses). Bit 16 is the reached-zero flag. All other control bits read 0, whatever was written.
- R4: In the clock edge after enable is seen with a nonzero reload, the live count takes the reload value. It then decrements by one per step.
- R5: The step that takes the count from 1 to 0 sets the flag. If interrupt enable is 1, the irq output is high for exactly the following cycle; irq is never high while the count is nonzero.
- R6: One clock after reaching 0, the count refills from the reload register without waiting for a step. A reload of 0 leaves the counter stopped at 0 until a nonzero reload is written.
- R7: A read of the control register clears the flag at that clock edge. If the count reaches 0 at the same edge, the flag ends up set.
- R8: Any write to 0x18 makes the count 0 and clears the flag with no irq pulse. A running counter then refills one clock later.
- R9: In reference-tick mode the count changes only on clocks where ref_tick is 1.
- R10: Clearing enable freezes the live count at its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-clock pulse of the external reference, used as the step in reference mode |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_sel |
| irq | output | 1 | One-cycle interrupt request on reaching zero |

## Verification
The functions that can coincide are the read-to-clear of the control register and the count reaching zero. Both land on the same clock edge when a control read is issued in the cycle where the live count is 1. The bench places such a read by counting cycles from the enable write. It expects that read to return the flag as 0. It then expects the following control read to return the flag as 1, because the set must win. A second overlap, a live-count write against a running count, is judged by a flag of 0 and an immediate refill.

// File: rtl/tick_pkg.sv
package tick_pkg;

    // Register offsets; software and the address decoder both depend on them.
    localparam int OFS_CTRL   = 'h10;
    localparam int OFS_RELOAD = 'h14;
    localparam int OFS_COUNT  = 'h18;
    localparam int OFS_CALIB  = 'h1C;

    // Control register bit positions.
    localparam int CB_EN    = 0;
    localparam int CB_IRQEN = 1;
    localparam int CB_SRC   = 2;
    localparam int CB_FLAG  = 16;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_WRAP = 2'd2
    } tick_state_e;

    typedef struct packed {
        logic src_core;
        logic irq_en;
        logic en;
    } tick_ctrl_t;

endpackage

// File: rtl/tick_regs.sv
module tick_regs
    import tick_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter bit CAL_NOREF = 1'b0,
    parameter bit CAL_SKEW  = 1'b1,
    parameter logic [CNT_W-1:0] CAL_TENMS = CNT_W'(100000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              hit_zero,
    output tick_ctrl_t        ctrl,
    output logic [CNT_W-1:0]  reload_val,
    output logic              cur_wr
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_CALIB  = ADDR_W'(OFS_CALIB);
    localparam int PAD_W = DATA_W - CNT_W - 2;

    logic flag_q;
    logic ctrl_wr, reload_wr, ctrl_rd;
    logic unused_wdata;

    assign ctrl_wr   = bus_sel &&  bus_wr && (bus_addr == A_CTRL);
    assign reload_wr = bus_sel &&  bus_wr && (bus_addr == A_RELOAD);
    assign cur_wr    = bus_sel &&  bus_wr && (bus_addr == A_COUNT);
    assign ctrl_rd   = bus_sel && !bus_wr && (bus_addr == A_CTRL);
    assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl       <= '0;
            reload_val <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl.en       <= bus_wdata[CB_EN];
                ctrl.irq_en   <= bus_wdata[CB_IRQEN];
                ctrl.src_core <= bus_wdata[CB_SRC];
            end
            if (reload_wr)
                reload_val <= bus_wdata[CNT_W-1:0];
        end
    end

    // Sticky flag: a zero event at the same edge outranks the clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit_zero)
            flag_q <= 1'b1;
        else if (ctrl_rd || cur_wr)
            flag_q <= 1'b0;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                A_CTRL: begin
                    bus_rdata[CB_EN]    = ctrl.en;
                    bus_rdata[CB_IRQEN] = ctrl.irq_en;
                    bus_rdata[CB_SRC]   = ctrl.src_core;
                    bus_rdata[CB_FLAG]  = flag_q;
                end
                A_RELOAD: bus_rdata[CNT_W-1:0] = reload_val;
                A_COUNT:  bus_rdata[CNT_W-1:0] = cnt;
                A_CALIB:  bus_rdata = {CAL_NOREF, CAL_SKEW, {PAD_W{1'b0}}, CAL_TENMS};
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R7: a zero event always leaves the flag set
    a_r7_zero_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hit_zero |=> flag_q);

    // R8: a count write clears the flag
    a_r8_write_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_wr && !hit_zero) |=> !flag_q);

    // R3: reserved control bits read zero
    a_r3_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd |-> (bus_rdata[DATA_W-1:CB_FLAG+1] == '0 && bus_rdata[CB_FLAG-1:CB_SRC+1] == '0));

endmodule

// File: rtl/tick_engine.sv
module tick_engine
    import tick_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  tick_ctrl_t       ctrl,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             cur_wr,
    output logic [CNT_W-1:0] cnt,
    output logic             hit_zero,
    output logic             irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tick_state_e      state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             step;
    logic             irq_q;

    assign step = ctrl.src_core ? 1'b1 : ref_tick;

    // State and count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n  = state_q;
        cnt_n    = cnt_q;
        hit_zero = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (cur_wr)
                    cnt_n = '0;
                else if (ctrl.en && reload_val != '0) begin   // start
                    cnt_n   = reload_val;
                    state_n = ST_RUN;
                end
            end
            ST_RUN: begin
                if (cur_wr) begin
                    cnt_n   = '0;
                    state_n = ctrl.en ? ST_WRAP : ST_OFF;
                end else if (!ctrl.en) begin                  // halt
                    state_n = ST_OFF;
                end else if (step) begin
                    if (cnt_q == ONE) begin                    // expire
                        cnt_n    = '0;
                        hit_zero = 1'b1;
                        state_n  = ST_WRAP;
                    end else begin
                        cnt_n = cnt_q - ONE;
                    end
                end
            end
            ST_WRAP: begin
                if (!ctrl.en || reload_val == '0) begin       // park
                    cnt_n   = '0;
                    state_n = ST_OFF;
                end else begin                                // refill
                    cnt_n   = reload_val;
                    state_n = ST_RUN;
                end
            end
            default: begin
                cnt_n   = '0;
                state_n = ST_OFF;
            end
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= hit_zero && ctrl.irq_en;
    end

    assign cnt = cnt_q;
    assign irq = irq_q;

    // R5: interrupt only while the count is zero
    a_r5_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt_q == '0));

    // R5: interrupt is a single-cycle pulse
    a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8: a count write never raises an interrupt
    a_r8_write_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> !irq);

    // R9: without a step the running count holds
    a_r9_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ctrl.en && !cur_wr && !step) |=> $stable(cnt_q));

    // R6: the zero cycle is always followed by a refill or a park
    a_r6_wrap_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRAP) |=> (state_q != ST_WRAP));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter bit CAL_NOREF = 1'b0,
    parameter bit CAL_SKEW  = 1'b1,
    parameter logic [CNT_W-1:0] CAL_TENMS = CNT_W'(100000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    tick_ctrl_t       ctrl;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cnt;
    logic             cur_wr;
    logic             hit_zero;

    tick_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .CAL_NOREF(CAL_NOREF), .CAL_SKEW(CAL_SKEW), .CAL_TENMS(CAL_TENMS)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt), .hit_zero(hit_zero),
        .ctrl(ctrl), .reload_val(reload_val), .cur_wr(cur_wr)
    );

    tick_engine #(.CNT_W(CNT_W)) i_engine (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .ctrl(ctrl), .reload_val(reload_val), .cur_wr(cur_wr),
        .cnt(cnt), .hit_zero(hit_zero), .irq(irq)
    );

endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [7:0] A_CTRL = 8'h10, A_RLD = 8'h14, A_CUR = 8'h18, A_CAL = 8'h1C;

    always #4 clk = ~clk;   // 125 MHz

    tick_timer i_tick_timer (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Monitor: compares every read against the scoreboard queue
    always @(negedge clk) begin
        if (bus_sel && !bus_wr) begin
            logic [31:0] e;
            string t;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: read with no expected item, actual %h expected none", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(t);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1; ref_tick = 1;
        @(posedge clk); #1; ref_tick = 0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_cmp++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq actual %b expected %b", t, irq, e);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset values and calibration word
        rd(A_CTRL, 32'h0, "R1 ctrl reset");
        rd(A_RLD,  32'h0, "R1 reload reset");
        rd(A_CUR,  32'h0, "R1 count reset");
        rd(A_CAL,  32'h4001_86A0, "R1 calibration");
        wr(A_CAL,  32'hFFFF_FFFF);
        rd(A_CAL,  32'h4001_86A0, "R1 calibration write ignored");
        chk_irq(1'b0, "R1 irq reset");
        // R2 / R3 masking
        rd(8'h20, 32'h0, "R2 unmapped address");
        wr(A_CTRL, 32'hFFFF_FFF8);
        rd(A_CTRL, 32'h0, "R3 reserved ctrl bits");
        wr(A_RLD, 32'hFF00_0005);
        rd(A_RLD, 32'h0000_0005, "R2 reload upper bits");
        // R4/R5/R6/R7 core-clock mode; enable applied at edge E0
        wr(A_CTRL, 32'h7);
        rd(A_CUR, 32'd5, "R4 loaded after enable");
        rd(A_CUR, 32'd3, "R4 decrement");
        rd(A_CUR, 32'd1, "R4 decrement to one");
        chk_irq(1'b1, "R5 irq at zero");
        rd(A_CTRL, 32'h0001_0007, "R5 flag set");
        chk_irq(1'b0, "R5 irq one cycle");
        rd(A_CUR, 32'd3, "R6 refill after zero");
        rd(A_CTRL, 32'h0000_0007, "R7 read clears flag, collision read");
        rd(A_CTRL, 32'h0001_0007, "R7 set wins over clear");
        // R10 disable freezes
        wr(A_CTRL, 32'h6);
        rd(A_CUR, 32'd2, "R10 frozen");
        rd(A_CUR, 32'd2, "R10 still frozen");
        // R8/R9 reference-tick mode
        wr(A_RLD, 32'd2);
        wr(A_CUR, 32'hABCD);
        rd(A_CUR, 32'd0, "R8 write zeroes count");
        wr(A_CTRL, 32'h1);
        rd(A_CUR, 32'd2, "R9 loaded");
        rd(A_CUR, 32'd2, "R9 no tick no change");
        tick();
        rd(A_CUR, 32'd1, "R9 one tick");
        tick();
        chk_irq(1'b0, "R5 irq masked when disabled");
        rd(A_CUR, 32'd2, "R6 refill without tick");
        wr(A_CUR, 32'h1);
        chk_irq(1'b0, "R8 no irq on write");
        rd(A_CTRL, 32'h0000_0001, "R8 write clears flag");
        rd(A_CUR, 32'd2, "R8 refill after write");
        // R6 reload 0 stops
        wr(A_RLD, 32'd0);
        tick();
        tick();
        tick();
        rd(A_CUR, 32'd0, "R6 stopped at zero");
        rd(A_CTRL, 32'h0001_0001, "R6 flag from last expiry");
        wr(A_RLD, 32'd3);
        rd(A_CUR, 32'd3, "R6 restart after nonzero reload");
        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        summary();
        $finish;
    end

endmodule